// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-side controller of an 8192-byte serial memory that answers as a slave on a two-wire bus. It resynchronises the clock and data lines to a system clock, recognises start and stop conditions, compares the incoming device byte against a fixed prefix and three pin-strapped address bits, and acknowledges the bytes it accepts by pulling the data line low.

A persistent word pointer survives from one transaction to the next. A write transaction loads the pointer from a two-byte word address. Each following data byte is handed to a separate page-programming block as a one-cycle strobe carrying address and data. Reads come from a storage array reached through a combinational read port. The pointer supplies the address, so current-address, random (dummy write then repeated start) and sequential reads share one path, and the pointer wraps over the whole array. While a program cycle runs, an external busy input keeps the slave silent towards its own address.

Top module: `eeprom_bus_slave`

## Requirements
- R1: After reset the data pull-down is released, no write strobe is issued, and the word pointer is 0, so a first current-address read returns the byte at address 0.
- R2: A device byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal pin_addr_i[2:0]. Bit 0 selects the direction, with 1 meaning read. Any other device byte gets no acknowledge and SDA stays released.
- R3: When busy_i is high at the end of a device byte that would otherwise match, the slave gives no acknowledge and leaves SDA released.
- R4: In a write transaction, the device byte has bit 0 = 0, followed by a high word-address byte (its low 5 bits used) and a low word-address byte, each acknowledged. Every following data byte is acknowledged and emitted as a one-cycle wr_valid_o pulse, with wr_addr_o equal to the pointer and wr_data_o equal to the byte. The pointer then advances by one.
- R5: A read with no preceding word address returns the byte at the last accessed address plus one, whether that access was a read or a write.
- R6: A write-direction device byte and two word-address bytes, followed by a repeated start and a read-direction device byte, return the byte at the given address and issue no write strobe.
- R7: Each master acknowledge after a transmitted byte makes the slave send the byte at the next address.
- R8: The pointer steps from address 8191 to address 0 during a sequential read.
- R9: A master non-acknowledge ends the transmission, and SDA stays released for any further clocks until the next start.
- R10: A stop seen in the middle of a byte returns the slave to idle with no write strobe and an unchanged pointer. A start seen in the middle of a byte restarts device-byte reception.
- R11: The SDA pull-down changes only while SCL is low, so an acknowledge or a data bit is held through the whole high phase of its clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| pin_addr_i | input | 3 | Strapped device-select bits |
| busy_i | input | 1 | Program cycle running; own address not answered |
| rd_addr_o | output | 13 | Storage read address (the word pointer) |
| rd_data_i | input | 8 | Storage read data, combinational from rd_addr_o |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted write data byte |
| wr_addr_o | output | 13 | Address of the accepted write byte |
| wr_data_o | output | 8 | Accepted write byte |

## Verification
Two decisions can meet in the same system-clock cycle: the busy gate and the device-address match are both resolved on the SCL falling edge that ends the eighth bit of the device byte. The bench raises busy_i just before the last address bit, so both land in that one decision cycle, and it judges the result at the ninth-clock sample. No acknowledge may appear there. A later transaction with busy_i low must then read from the unchanged pointer.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK
   } eeb_state_e;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_DATA
   } eeb_phase_e;
endpackage

// File: rtl/eeb_sync.sv
module eeb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];

   assign lvl_o  = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~prev;
   assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/eeb_cond.sv
module eeb_cond (
   input  logic scl_lvl_i,
   input  logic scl_rise_i,
   input  logic sda_rise_i,
   input  logic sda_fall_i,
   output logic start_o,
   output logic stop_o
);
   logic scl_held;
   assign scl_held = scl_lvl_i & ~scl_rise_i;
   assign start_o  = scl_held & sda_fall_i;
   assign stop_o   = scl_held & sda_rise_i;
endmodule

// File: rtl/eeb_ptr.sv
module eeb_ptr #(
   parameter int AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          inc_i,
   output logic [AW-1:0] ptr_o
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= load_val_i;
      else if (inc_i)  ptr_o <= ptr_o + 1'b1;
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
   import eeb_pkg::*;
#(
   parameter int         ADDR_W      = 13,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [2:0]        pin_addr_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o
);
   localparam int HI_W  = ADDR_W - 8;
   localparam int CNT_W = 4;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must fit two address bytes and exceed one");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_det, stop_det;

   eeb_sync #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   eeb_sync #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   eeb_cond u_cond (
      .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise),
      .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
      .start_o(start_det), .stop_o(stop_det));

   eeb_state_e        state;
   eeb_phase_e        phase;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        rx_sh;
   logic [7:0]        tx_sh;
   logic [HI_W-1:0]   hi_q;
   logic              is_read;
   logic              mack;
   logic              pull;
   logic [ADDR_W-1:0] ptr;

   logic quiet, byte_done, dev_hit, ptr_load, ptr_inc;

   assign quiet     = ~start_det & ~stop_det;
   assign byte_done = quiet & (state == ST_RX) & scl_fall & (cnt == CNT_W'(8));
   assign dev_hit   = (rx_sh[7:4] == DEV_PREFIX) & (rx_sh[3:1] == pin_addr_i) & ~busy_i;

   always_comb begin
      ptr_load = byte_done & (phase == PH_ALO);
      ptr_inc  = (byte_done & (phase == PH_DATA))
               | (quiet & (state == ST_RXACK) & scl_fall & (phase == PH_DEV) & is_read)
               | (quiet & (state == ST_TXACK) & scl_fall & mack);
   end

   eeb_ptr #(.AW(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
      .load_val_i({hi_q, rx_sh}), .inc_i(ptr_inc), .ptr_o(ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_DEV;
         cnt        <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         hi_q       <= '0;
         is_read    <= 1'b0;
         mack       <= 1'b0;
         pull       <= 1'b0;
         wr_valid_o <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_valid_o <= 1'b0;
         if (stop_det) begin
            state <= ST_IDLE;
            pull  <= 1'b0;
         end else if (start_det) begin
            state <= ST_RX;
            phase <= PH_DEV;
            cnt   <= '0;
            pull  <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && cnt != CNT_W'(8)) begin
                     rx_sh <= {rx_sh[6:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     case (phase)
                        PH_DEV: begin
                           if (dev_hit) begin
                              pull    <= 1'b1;
                              is_read <= rx_sh[0];
                              state   <= ST_RXACK;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        PH_AHI: begin
                           hi_q  <= rx_sh[HI_W-1:0];
                           pull  <= 1'b1;
                           state <= ST_RXACK;
                        end
                        PH_ALO: begin
                           pull  <= 1'b1;
                           state <= ST_RXACK;
                        end
                        default: begin
                           wr_valid_o <= 1'b1;
                           wr_addr_o  <= ptr;
                           wr_data_o  <= rx_sh;
                           pull       <= 1'b1;
                           state      <= ST_RXACK;
                        end
                     endcase
                  end
               end
               ST_RXACK: begin
                  if (scl_fall) begin
                     if (phase == PH_DEV && is_read) begin
                        tx_sh <= rd_data_i;
                        pull  <= ~rd_data_i[7];
                        cnt   <= '0;
                        state <= ST_TX;
                     end else begin
                        pull  <= 1'b0;
                        state <= ST_RX;
                        phase <= (phase == PH_DATA) ? PH_DATA : eeb_phase_e'(phase + 2'd1);
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(7)) begin
                        pull  <= 1'b0;
                        state <= ST_TXACK;
                     end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        pull  <= ~tx_sh[6];
                        cnt   <= cnt + 1'b1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx_sh <= rd_data_i;
                        pull  <= ~rd_data_i[7];
                        cnt   <= '0;
                        state <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull;
   assign rd_addr_o  = ptr;
endmodule

// File: rtl/eeb_check.sv
module eeb_check
   import eeb_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_lvl,
   input logic       start_det,
   input logic       stop_det,
   input eeb_state_e state,
   input eeb_phase_e phase,
   input logic       busy_i,
   input logic       sda_pull_o,
   input logic       wr_valid_o
);
   // R11: pull-down never moves while the synchronised clock stays high
   p_scl_high_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull_o));

   // R10: a stop lands the slave in idle with the line released
   p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE) && !sda_pull_o);

   // R10: a start restarts device-byte reception
   p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (state == ST_RX) && (phase == PH_DEV));

   // R3: busy during device-byte reception never yields an acknowledge
   p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && state == ST_RX && phase == PH_DEV) |=> !sda_pull_o);

   // R4: the write strobe lasts a single cycle
   p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);
endmodule

bind eeprom_bus_slave eeb_check u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
   .start_det(start_det), .stop_det(stop_det),
   .state(state), .phase(phase), .busy_i(busy_i),
   .sda_pull_o(sda_pull_o), .wr_valid_o(wr_valid_o));

// File: tb/eeprom_bus_slave_test.sv
module eeprom_bus_slave_test;
   localparam int CLK_P = 10;
   localparam int Q     = 6;
   localparam logic [7:0] DEV_W = 8'hAA;
   localparam logic [7:0] DEV_R = 8'hAB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        busy = 1'b0;
   logic        pull;
   logic [12:0] rd_addr;
   logic [7:0]  rd_data;
   logic        wr_valid;
   logic [12:0] wr_addr;
   logic [7:0]  wr_data;
   logic        sda_line;

   int n_chk = 0;
   int n_bad = 0;
   int wr_n = 0;
   logic [12:0] last_wa = '0;
   logic [7:0]  last_wd = '0;
   int r11_viol = 0;
   logic scl_prev = 1'b1;
   logic pull_prev = 1'b0;
   logic done = 1'b0;
   logic [12:0] ptr_exp = '0;

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] mem_f(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b011};
   endfunction

   assign rd_data  = mem_f(rd_addr);
   assign sda_line = sda_m & ~pull;

   eeprom_bus_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(pull), .pin_addr_i(3'b101), .busy_i(busy),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

   always @(posedge clk)
      if (wr_valid) begin
         wr_n++;
         last_wa = wr_addr;
         last_wd = wr_data;
      end

   always @(negedge clk) begin
      if (scl_m && scl_prev && pull != pull_prev) r11_viol++;
      scl_prev  = scl_m;
      pull_prev = pull;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_w(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bit_r(output logic b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic do_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, input int busy_at, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         if (i == busy_at) busy = 1'b1;
         bit_w(b[i]);
      end
      bit_r(x);
      ack = ~x;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) bit_r(b[i]);
      bit_w(~mack);
   endtask

   task automatic set_addr(input logic [12:0] a, input string req);
      logic ack;
      do_start();
      send_byte(DEV_W, -1, ack); check({req, " dev ack"}, ack, 1);
      send_byte({3'b000, a[12:8]}, -1, ack); check({req, " hi ack"}, ack, 1);
      send_byte(a[7:0], -1, ack); check({req, " lo ack"}, ack, 1);
      ptr_exp = a;
   endtask

   task automatic read_cur(input string req);
      logic ack;
      logic [7:0] d;
      do_start();
      send_byte(DEV_R, -1, ack); check({req, " read ack"}, ack, 1);
      recv_byte(1'b0, d); check({req, " data"}, d, mem_f(ptr_exp));
      ptr_exp++;
      do_stop();
   endtask

   task automatic t_reset();
      check("R1 pull released", pull, 0);
      check("R1 no strobe", wr_valid, 0);
      read_cur("R1 first read at 0");
   endtask

   task automatic t_match();
      logic ack;
      do_start(); send_byte(8'hA2, -1, ack); check("R2 wrong pins", ack, 0); do_stop();
      do_start(); send_byte(8'hBA, -1, ack); check("R2 wrong prefix", ack, 0); do_stop();
      read_cur("R2 matching address");
   endtask

   task automatic t_write();
      logic ack;
      int n0;
      n0 = wr_n;
      set_addr(13'h1234, "R4");
      send_byte(8'h5A, -1, ack); check("R4 data ack", ack, 1);
      check("R4 strobe count", wr_n - n0, 1);
      check("R4 addr", last_wa, 13'h1234);
      check("R4 data", last_wd, 8'h5A);
      send_byte(8'hC3, -1, ack);
      check("R4 second addr", last_wa, 13'h1235);
      check("R4 second data", last_wd, 8'hC3);
      do_stop();
      ptr_exp = 13'h1236;
      read_cur("R5 read after write");
   endtask

   task automatic t_random();
      logic ack;
      logic [7:0] d;
      int n0;
      n0 = wr_n;
      set_addr(13'h0040, "R6");
      do_start();
      send_byte(DEV_R, -1, ack); check("R6 read ack", ack, 1);
      recv_byte(1'b0, d); check("R6 data", d, mem_f(13'h0040));
      do_stop();
      check("R6 no write strobe", wr_n - n0, 0);
      ptr_exp = 13'h0041;
      read_cur("R5 read after read");
   endtask

   task automatic t_seq(input logic [12:0] a, input int n, input string req);
      logic ack;
      logic [7:0] d;
      set_addr(a, req);
      do_start();
      send_byte(DEV_R, -1, ack);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, d);
         check(req, d, mem_f(ptr_exp));
         ptr_exp++;
      end
      do_stop();
   endtask

   task automatic t_nack();
      logic ack;
      logic [7:0] d;
      logic x;
      int seen;
      do_start();
      send_byte(DEV_R, -1, ack);
      recv_byte(1'b0, d); check("R9 data", d, mem_f(ptr_exp));
      ptr_exp++;
      seen = 0;
      for (int i = 0; i < 9; i++) begin bit_r(x); if (!x) seen++; end
      check("R9 line stays released", seen, 0);
      do_stop();
   endtask

   task automatic t_busy();
      logic ack;
      busy = 1'b1;
      do_start(); send_byte(DEV_R, -1, ack); check("R3 busy no ack", ack, 0); do_stop();
      busy = 1'b0;
      do_start(); send_byte(DEV_R, 0, ack); check("R3 busy at last bit", ack, 0); do_stop();
      busy = 1'b0;
      read_cur("R3 pointer kept");
   endtask

   task automatic t_abort();
      logic ack;
      int n0;
      n0 = wr_n;
      do_start(); send_byte(DEV_W, -1, ack);
      for (int i = 0; i < 4; i++) bit_w(1'b0);
      do_stop();
      read_cur("R10 stop mid-byte");
      set_addr(13'h0777, "R10");
      for (int i = 0; i < 5; i++) bit_w(1'b1);
      do_stop();
      check("R10 no strobe on abort", wr_n - n0, 0);
      read_cur("R10 pointer after stop");
      do_start(); send_byte(DEV_W, -1, ack);
      for (int i = 0; i < 3; i++) bit_w(1'b0);
      read_cur("R10 start mid-byte");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_match();
      t_write();
      t_random();
      t_seq(13'h0100, 4, "R7 sequential");
      t_seq(13'h1FFE, 3, "R8 wrap");
      read_cur("R8 after wrap");
      t_nack();
      t_busy();
      t_abort();
      check("R11 pull stable while SCL high", r11_viol, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule